// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate Unit

This block multiplies two 16-bit operands and writes the product into a 40-bit accumulator. The write can load the product, add it to the running value or subtract it from the running value. Each operand is treated as signed or unsigned on its own, so four signedness combinations are available. An optional rounding step acts on the 40-bit result before the result is stored.

The accumulator is presented as three output slices: an 8-bit top, a 16-bit middle and a 16-bit low word. A registered flag shows when the stored value no longer fits in a 32-bit signed word. A synchronous clear input sets the accumulator and the flag to zero. The caller marks each operation with a valid strobe. The new value appears on the outputs one clock after that strobe.

Top module: `mixmac_unit`

## Requirements
- R1: After reset, `acc_top`, `acc_mid`, `acc_low` and `ovf` are all zero.
- R2: With `in_valid` high and `op` = 2'b00 (load), the accumulator takes the product `x*y` extended to 40 bits.
- R3: `sign_mode[1]` = 1 treats `x` as two's complement, and 0 treats it as unsigned. `sign_mode[0]` does the same for `y`. The product is sign-extended to 40 bits, so when both operands are unsigned it is effectively zero-extended.
- R4: `op` = 2'b01 (add) stores the old accumulator plus the product, modulo 2^40.
- R5: `op` = 2'b10 (subtract) stores the old accumulator minus the product, modulo 2^40.
- R6: When `round_en` is high on an operation, 0x8000 is added to the 40-bit result and bits 15:0 are then cleared before the result is stored. The carry from this step propagates into bit 16 and above.
- R7: `ovf` is registered together with each stored result. It is 1 exactly when bits 39:31 of that result are not all equal.
- R8: `clear` high sets the accumulator and `ovf` to zero on the next edge. It takes priority over `in_valid`.
- R9: With `in_valid` low, or with `op` = 2'b11, the accumulator and `ovf` keep their values whatever the other inputs are.
- R10: A result caused by inputs sampled at one rising edge is visible on the outputs immediately after that edge. This gives one cycle of latency, and back-to-back operations are supported.
- R11: `acc_low` is accumulator bits 15:0, `acc_mid` is bits 31:16 and `acc_top` is bits 39:32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| sign_mode | input | 2 | Bit 1: x signed; bit 0: y signed |
| op | input | 2 | 00 load, 01 add, 10 subtract, 11 no change |
| round_en | input | 1 | Apply rounding to this result |
| clear | input | 1 | Synchronous zeroing of accumulator and flag |
| acc_top | output | 8 | Accumulator bits 39:32 |
| acc_mid | output | 16 | Accumulator bits 31:16 |
| acc_low | output | 16 | Accumulator bits 15:0 |
| ovf | output | 1 | Result exceeds 32-bit signed range |

## Verification
Every result is due exactly one rising edge after the inputs that cause it: the three slices, the flag, a clear and a hold all follow this rule. The bench drives the inputs on the falling edge and advances its behavioural model at the same moment. It compares all four outputs shortly after the next rising edge, so each comparison sees the first cycle in which the new value is valid. Because the comparison runs on every cycle, holds are covered as well as updates. Directed sequences cover the sign corners, rounding carries and overflow entry and exit. A random stream then follows.

// File: rtl/mixmac_pkg.sv
package mixmac_pkg;

   typedef enum logic [1:0] {
      MAC_LOAD = 2'b00,
      MAC_ADD  = 2'b01,
      MAC_SUB  = 2'b10,
      MAC_KEEP = 2'b11
   } mac_op_e;

   typedef struct packed {
      logic x_signed;
      logic y_signed;
   } sign_sel_t;

endpackage

// File: rtl/mixmac_mult.sv
module mixmac_mult #(
   parameter int XW = 16,
   parameter int YW = 16,
   parameter int AW = 40
) (
   input  logic [XW-1:0] x,
   input  logic [YW-1:0] y,
   input  logic          x_signed,
   input  logic          y_signed,
   output logic [AW-1:0] prod
);
   localparam int PW = XW + YW + 2;

   logic signed [XW:0]   x_ext;
   logic signed [YW:0]   y_ext;
   logic signed [PW-1:0] prod_full;

   // The extra top bit carries the sign only when the operand is signed.
   assign x_ext     = {x_signed & x[XW-1], x};
   assign y_ext     = {y_signed & y[YW-1], y};
   assign prod_full = PW'(x_ext) * PW'(y_ext);

   generate
      if (AW > PW) begin : g_extend
         assign prod = {{(AW-PW){prod_full[PW-1]}}, prod_full};
      end else begin : g_trunc
         assign prod = prod_full[AW-1:0];
      end
   endgenerate

endmodule

// File: rtl/mixmac_accum.sv
module mixmac_accum
   import mixmac_pkg::*;
#(
   parameter int AW      = 40,
   parameter int RND_POS = 15
) (
   input  logic [AW-1:0] acc_now,
   input  logic [AW-1:0] prod,
   input  mac_op_e       op,
   input  logic          round_en,
   output logic [AW-1:0] result
);
   localparam logic [AW-1:0] RND_ADD  = AW'(1) << RND_POS;
   localparam logic [AW-1:0] RND_KEEP = ~((RND_ADD << 1) - AW'(1));

   logic [AW-1:0] raw;

   always_comb begin
      unique case (op)
         MAC_LOAD: raw = prod;
         MAC_ADD:  raw = acc_now + prod;
         MAC_SUB:  raw = acc_now - prod;
         default:  raw = acc_now;
      endcase
   end

   always_comb begin
      if (round_en) result = (raw + RND_ADD) & RND_KEEP;
      else          result = raw;
   end

endmodule

// File: rtl/mixmac_ovf.sv
module mixmac_ovf #(
   parameter int AW    = 40,
   parameter int SAT_W = 32
) (
   input  logic [AW-1:0] value,
   output logic          out_of_range
);
   localparam int GW = AW - SAT_W + 1;

   logic [GW-1:0] guard;

   assign guard        = value[AW-1:SAT_W-1];
   assign out_of_range = !((&guard) || !(|guard));

endmodule

// File: rtl/mixmac_unit.sv
module mixmac_unit
   import mixmac_pkg::*;
#(
   parameter int XW      = 16,
   parameter int YW      = 16,
   parameter int AW      = 40,
   parameter int LOW_W   = 16,
   parameter int MID_W   = 16,
   parameter int SAT_W   = 32,
   parameter int RND_POS = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [XW-1:0]            x,
   input  logic [YW-1:0]            y,
   input  logic [1:0]               sign_mode,
   input  logic [1:0]               op,
   input  logic                     round_en,
   input  logic                     clear,
   output logic [AW-LOW_W-MID_W-1:0] acc_top,
   output logic [MID_W-1:0]         acc_mid,
   output logic [LOW_W-1:0]         acc_low,
   output logic                     ovf
);
   localparam int TOP_W  = AW - LOW_W - MID_W;
   localparam int MID_LO = LOW_W;
   localparam int TOP_LO = LOW_W + MID_W;

   generate
      if (AW < XW + YW + 1) begin : g_chk_aw
         $error("mixmac_unit: accumulator narrower than product");
      end
      if (TOP_W < 1) begin : g_chk_split
         $error("mixmac_unit: slice widths leave no top part");
      end
      if (SAT_W > AW || SAT_W < 2) begin : g_chk_sat
         $error("mixmac_unit: range width out of bounds");
      end
      if (RND_POS >= AW - 1 || RND_POS < 0) begin : g_chk_rnd
         $error("mixmac_unit: rounding position out of bounds");
      end
   endgenerate

   sign_sel_t     sel;
   logic [AW-1:0] prod;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] next_val;
   logic          next_ovf;
   logic          ovf_q;
   logic          take;

   assign sel  = sign_sel_t'(sign_mode);
   assign take = in_valid && (mac_op_e'(op) != MAC_KEEP);

   mixmac_mult #(.XW(XW), .YW(YW), .AW(AW)) u_mult (
      .x        (x),
      .y        (y),
      .x_signed (sel.x_signed),
      .y_signed (sel.y_signed),
      .prod     (prod)
   );

   mixmac_accum #(.AW(AW), .RND_POS(RND_POS)) u_accum (
      .acc_now  (acc_q),
      .prod     (prod),
      .op       (mac_op_e'(op)),
      .round_en (round_en),
      .result   (next_val)
   );

   mixmac_ovf #(.AW(AW), .SAT_W(SAT_W)) u_ovf (
      .value        (next_val),
      .out_of_range (next_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (clear) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (take) begin
         acc_q <= next_val;
         ovf_q <= next_ovf;
      end
   end

   assign acc_low = acc_q[LOW_W-1:0];
   assign acc_mid = acc_q[TOP_LO-1:MID_LO];
   assign acc_top = acc_q[AW-1:TOP_LO];
   assign ovf     = ovf_q;

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0 && !ovf_q)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !in_valid) |=> ($stable(acc_q) && $stable(ovf_q))); // R9
   AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && in_valid && op == 2'b11) |=> $stable(acc_q)); // R9
   AST_ROUND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && take && round_en) |=> (acc_low == '0)); // R6
   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && in_valid && op == 2'b00 && !round_en) |=> (acc_q == $past(prod))); // R2
   AST_OVF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf == !((&acc_q[AW-1:SAT_W-1]) || !(|acc_q[AW-1:SAT_W-1]))); // R7

endmodule

// File: tb/mixmac_unit_test.sv
module mixmac_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] x = '0;
   logic [15:0] y = '0;
   logic [1:0]  sign_mode = '0;
   logic [1:0]  op = '0;
   logic        round_en = 1'b0;
   logic        clear = 1'b0;
   logic [7:0]  acc_top;
   logic [15:0] acc_mid;
   logic [15:0] acc_low;
   logic        ovf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [39:0] m_acc = '0;
   logic        m_ovf = 1'b0;

   always #4 clk = ~clk;

   mixmac_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x), .y(y),
      .sign_mode(sign_mode), .op(op), .round_en(round_en), .clear(clear),
      .acc_top(acc_top), .acc_mid(acc_mid), .acc_low(acc_low), .ovf(ovf)
   );

   task automatic check(input string tag);
      logic [39:0] got;
      got = {acc_top, acc_mid, acc_low};
      checks++;
      if (got !== m_acc) begin
         fails++;
         $display("FAIL %s acc act=%h exp=%h", tag, got, m_acc);
      end
      checks++;
      if (ovf !== m_ovf) begin
         fails++;
         $display("FAIL %s ovf act=%b exp=%b", tag, ovf, m_ovf);
      end
   endtask

   // Behavioural model: plain integer arithmetic, wrapped to 40 bits.
   task automatic model(input logic v, input logic [15:0] a, input logic [15:0] b,
                        input logic [1:0] sm, input logic [1:0] o,
                        input logic r, input logic c);
      longint av, bv, p, full;
      logic [39:0] res;
      if (c) begin
         m_acc = '0;
         m_ovf = 1'b0;
         return;
      end
      if (!v || o == 2'b11) return;
      av = sm[1] ? longint'($signed(a)) : longint'(a);
      bv = sm[0] ? longint'($signed(b)) : longint'(b);
      p  = av * bv;
      case (o)
         2'b00:   full = p;
         2'b01:   full = longint'($signed(m_acc)) + p;
         default: full = longint'($signed(m_acc)) - p;
      endcase
      if (r) full = ((full + 64'sd32768) / 64'sd65536) * 64'sd65536
                    - (((full + 64'sd32768) % 64'sd65536 < 0) ? 64'sd65536 : 64'sd0);
      res = full[39:0];
      m_acc = res;
      m_ovf = !(longint'($signed(res)) >= -64'sd2147483648 &&
                longint'($signed(res)) <=  64'sd2147483647);
   endtask

   task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                       input logic [1:0] sm, input logic [1:0] o,
                       input logic r, input logic c, input string tag);
      @(negedge clk);
      in_valid = v; x = a; y = b; sign_mode = sm; op = o; round_en = r; clear = c;
      model(v, a, b, sm, o, r, c);
      @(posedge clk);
      #1;
      check(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R10 watchdog act=hung exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R3: load in every sign combination
      step(1, 16'hFFFD, 16'h0005, 2'b11, 2'b00, 0, 0, "R2 R3 SS neg");
      step(1, 16'hFFFF, 16'hFFFF, 2'b11, 2'b00, 0, 0, "R3 SS -1*-1");
      step(1, 16'hFFFF, 16'h0002, 2'b10, 2'b00, 0, 0, "R3 SU");
      step(1, 16'h0002, 16'hFFFF, 2'b01, 2'b00, 0, 0, "R3 US");
      step(1, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 0, 0, "R3 R7 UU max");
      step(1, 16'h8000, 16'h8000, 2'b11, 2'b00, 0, 0, "R3 R11 SS min");
      step(1, 16'h8000, 16'hFFFF, 2'b10, 2'b00, 0, 0, "R3 R11 SU neg");
      // R4 add, R7 overflow entry
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b00, 0, 0, "R2 load");
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b01, 0, 0, "R4 add");
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b01, 0, 0, "R4 R7 add ovf");
      // R5 subtract, overflow exit and below zero
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b10, 0, 0, "R5 R7 sub");
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b10, 0, 0, "R5 sub");
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b10, 0, 0, "R5 sub zero");
      step(1, 16'h0003, 16'h0004, 2'b00, 2'b10, 0, 0, "R5 sub neg");
      // R9 idle and keep code
      step(0, 16'h1234, 16'h5678, 2'b00, 2'b00, 1, 0, "R9 idle");
      step(1, 16'h1234, 16'h5678, 2'b00, 2'b11, 1, 0, "R9 keep");
      // R6 rounding, including carry and negative values
      step(1, 16'h0001, 16'h8000, 2'b00, 2'b00, 1, 0, "R6 carry up");
      step(1, 16'h0001, 16'h7FFF, 2'b00, 2'b00, 1, 0, "R6 round down");
      step(1, 16'hFFFF, 16'h8000, 2'b10, 2'b00, 1, 0, "R6 neg half");
      step(1, 16'h1234, 16'h4321, 2'b11, 2'b01, 1, 0, "R6 add round");
      // R8 clear priority
      step(1, 16'h7FFF, 16'h7FFF, 2'b11, 2'b01, 0, 1, "R8 clear");
      step(1, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 0, 0, "R7 set");
      step(0, 16'h0000, 16'h0000, 2'b00, 2'b00, 0, 1, "R8 clear ovf");
      // R10 back-to-back random stream
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 4) != 0, 16'($urandom), 16'($urandom), 2'($urandom),
              2'($urandom), ($urandom % 3) == 0, ($urandom % 29) == 0, "R10 random");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule